// File: doc/BRIEF.md
# Ten-Counter Core Performance Monitor

This block counts hardware events for one processor core. It holds ten 48-bit counters. Counter 0 always counts clock cycles and counter 1 always counts retired instructions. Each of counters 2 to 9 picks one line of a 256-wide event strobe vector through an 8-bit selector. A counter advances only when three things hold: software has enabled it, its privilege filter allows the current level (user or kernel), and its chosen strobe is high.

When a counter's top bit (bit 47) goes from 0 to 1, a sticky overflow flag is set for that counter. If the overflow interrupt for that counter is enabled, the block raises one of three delivery lines, chosen by a mode field. It also sets a sticky interrupt-active flag, which software must clear. An optional freeze bit stops every counter while the active flag is set, so that the counts taken at the interrupt stay as they were.

Software reaches the block through a simple register port. A write takes effect on the clock edge. A read returns its data, with a valid strobe, one cycle after the request.

Top module: `perf_monitor`

## Requirements
- R1: Counters 0 to 9 are read and written at addresses 0x00 to 0x09 (48 bits, zero-extended to 64). A write to a counter takes priority over an increment in the same cycle.
- R2: Counter 0 advances on `cyc_stb` and counter 1 advances on `inst_stb`. Neither counter has a selector.
- R3: Selector register A (0x12) holds the event codes for counters 2, 3, 4 and 5 in bytes 0, 1, 2 and 3. Selector register B (0x13) holds the codes for counters 6, 7, 8 and 9 in the same byte order. A counter counts only the strobe `evt_stb[code]`; every other strobe line is ignored.
- R4: Control register A (0x10) holds the count enables: bits [7:0] for counters 0 to 7 and bits [33:32] for counters 8 and 9. A disabled counter holds its value.
- R5: Control register B (0x11) holds the privilege filters. User-level enables are in bits [15:8] for counters 0 to 7 and [41:40] for counters 8 and 9. Kernel-level enables are in bits [23:16] and [49:48]. `priv_kernel`=1 selects the kernel filter and 0 selects the user filter.
- R6: An increment that takes a counter's bit 47 from 0 to 1 sets that counter's bit in the status register (0x14, bits [9:0]). Status bits are sticky. Writing 1 to a status bit clears it, and a new overflow in the same cycle wins over the clear.
- R7: Control register A bits [19:12] (counters 0 to 7) and [45:44] (counters 8 and 9) enable the overflow interrupts. Bits [10:8] choose the delivery line: 1 drives `irq_pmi`, 3 drives `halt_req` and 4 drives `irq_fiq`. Any other value drives no line. The chosen line is high in the cycle after a status bit and its enable are both set.
- R8: Control register A bit 11 reads as the interrupt-active flag. It becomes set whenever an enabled overflow is pending with a mode other than 0. It stays set until software writes control register A with bit 11 at 0 and no enabled overflow is still pending.
- R9: When control register A bit 20 is set, no counter advances while the active flag is set.
- R10: After reset, all counters, control and selector registers, status, the active flag and the interrupt lines are 0.
- R11: A read issued with `reg_rd_en` returns data on `reg_rd_data`, with `reg_rd_valid` high, in the next cycle. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 5 | Write address |
| reg_wr_data | input | 64 | Write data |
| reg_rd_en | input | 1 | Register read request |
| reg_rd_addr | input | 5 | Read address |
| reg_rd_data | output | 64 | Read data, one cycle after the request |
| reg_rd_valid | output | 1 | Read data valid |
| cyc_stb | input | 1 | Cycle strobe for counter 0 |
| inst_stb | input | 1 | Retired-instruction strobe for counter 1 |
| evt_stb | input | 256 | Event strobes for selectable counters |
| priv_kernel | input | 1 | Current level: 1 kernel, 0 user |
| irq_pmi | output | 1 | Overflow interrupt, mode 1 |
| irq_fiq | output | 1 | Fast overflow interrupt, mode 4 |
| halt_req | output | 1 | Halt request on overflow, mode 3 |

## Verification
The assertions check four things on every cycle. A register write always lands in its counter. A frozen counter never moves. An overflow always leaves both bit 47 and its status bit set, and at most one delivery line is high, with none at all in mode 0. The active flag is also checked every cycle: it can only fall after a clearing write. The bench scenarios are the only way to show the rest: the exact counts under each privilege filter, that the high enable fields reach counters 8 and 9, that selector bytes sit in the right place, that unselected strobes are ignored, the one-cycle latency from overflow to interrupt line, and the order in which software must clear the status and active flags before counting resumes.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NCNT   = 10;
  localparam int REG_W  = 64;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRLA  = 5'h10;
  localparam logic [ADDR_W-1:0] A_CTRLB  = 5'h11;
  localparam logic [ADDR_W-1:0] A_SELA   = 5'h12;
  localparam logic [ADDR_W-1:0] A_SELB   = 5'h13;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'h14;

  // low field base (counters 0..7) and high field base (counters 8..9)
  localparam int EN_LO = 0,  EN_HI = 32;
  localparam int IE_LO = 12, IE_HI = 44;
  localparam int US_LO = 8,  US_HI = 40;
  localparam int KN_LO = 16, KN_HI = 48;
  localparam int MODE_LSB = 8;
  localparam int ACT_BIT  = 11;
  localparam int STOP_BIT = 20;

  localparam logic [2:0] MODE_OFF  = 3'd0;
  localparam logic [2:0] MODE_PMI  = 3'd1;
  localparam logic [2:0] MODE_HALT = 3'd3;
  localparam logic [2:0] MODE_FIQ  = 3'd4;

  localparam int SEL_FIRST = 2;   // first counter with an event selector
  localparam int SEL_PER_REG = 4;

  function automatic int field_pos(input int idx, input int lo, input int hi);
    return (idx < 8) ? lo + idx : hi + idx - 8;
  endfunction

  function automatic logic [REG_W-1:0] ctrla_mask();
    logic [REG_W-1:0] m = '0;
    for (int i = 0; i < NCNT; i++) begin
      m[field_pos(i, EN_LO, EN_HI)] = 1'b1;
      m[field_pos(i, IE_LO, IE_HI)] = 1'b1;
    end
    m[MODE_LSB +: 3] = 3'b111;
    m[STOP_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] ctrlb_mask();
    logic [REG_W-1:0] m = '0;
    for (int i = 0; i < NCNT; i++) begin
      m[field_pos(i, US_LO, US_HI)] = 1'b1;
      m[field_pos(i, KN_LO, KN_HI)] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pmu_ctrl_regs.sv
module pmu_ctrl_regs
  import pmu_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  output logic [NCNT-1:0]      cnt_en,
  output logic [NCNT-1:0]      int_en,
  output logic [NCNT-1:0]      usr_en,
  output logic [NCNT-1:0]      krn_en,
  output logic [NCNT-1:0][EVT_W-1:0] evsel,
  output logic [2:0]           mode,
  output logic                 stop_on_int,
  output logic [REG_W-1:0]     ctrla_q,
  output logic [REG_W-1:0]     ctrlb_q,
  output logic [REG_W-1:0]     sela_q,
  output logic [REG_W-1:0]     selb_q
);
  localparam logic [REG_W-1:0] MASK_A = ctrla_mask();
  localparam logic [REG_W-1:0] MASK_B = ctrlb_mask();
  localparam logic [REG_W-1:0] MASK_S = {{(REG_W-SEL_PER_REG*EVT_W){1'b0}}, {(SEL_PER_REG*EVT_W){1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrla_q <= '0;
      ctrlb_q <= '0;
      sela_q  <= '0;
      selb_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRLA: ctrla_q <= wr_data & MASK_A;
        A_CTRLB: ctrlb_q <= wr_data & MASK_B;
        A_SELA:  sela_q  <= wr_data & MASK_S;
        A_SELB:  selb_q  <= wr_data & MASK_S;
        default: ;
      endcase
    end
  end

  assign mode        = ctrla_q[MODE_LSB +: 3];
  assign stop_on_int = ctrla_q[STOP_BIT];

  for (genvar i = 0; i < NCNT; i++) begin : g_fld
    localparam int P_EN = field_pos(i, EN_LO, EN_HI);
    localparam int P_IE = field_pos(i, IE_LO, IE_HI);
    localparam int P_US = field_pos(i, US_LO, US_HI);
    localparam int P_KN = field_pos(i, KN_LO, KN_HI);
    assign cnt_en[i] = ctrla_q[P_EN];
    assign int_en[i] = ctrla_q[P_IE];
    assign usr_en[i] = ctrlb_q[P_US];
    assign krn_en[i] = ctrlb_q[P_KN];
    if (i < SEL_FIRST) begin : g_fixed
      assign evsel[i] = '0;
    end else if (i < SEL_FIRST + SEL_PER_REG) begin : g_sela
      assign evsel[i] = sela_q[(i - SEL_FIRST) * EVT_W +: EVT_W];
    end else begin : g_selb
      assign evsel[i] = selb_q[(i - SEL_FIRST - SEL_PER_REG) * EVT_W +: EVT_W];
    end
  end

  assert_ctrl_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrla_q & ~MASK_A) == '0);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             en,
  input  logic             usr_en,
  input  logic             krn_en,
  input  logic             priv_kernel,
  input  logic             freeze,
  input  logic             evt_hit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf
);
  localparam int MSB = CNT_W - 1;

  logic lvl_ok, inc;
  assign lvl_ok = priv_kernel ? krn_en : usr_en;
  assign inc    = en & evt_hit & lvl_ok & ~freeze;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wr_hit) cnt_q <= wr_val;
    else if (inc)    cnt_q <= cnt_q + 1'b1;
  end

  // bit MSB goes 0 -> 1 on this increment
  assign ovf = inc & ~wr_hit & ~cnt_q[MSB] & (&cnt_q[MSB-1:0]);

  assert_write_wins_R1: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> cnt_q == $past(wr_val));
  assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (freeze && !wr_hit) |=> $stable(cnt_q));
  assert_ovf_msb_R6: assert property (@(posedge clk) disable iff (rst)
    ovf |=> cnt_q[MSB]);
endmodule

// File: rtl/pmu_irq.sv
module pmu_irq
  import pmu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NCNT-1:0] ovf,
  input  logic [NCNT-1:0] int_en,
  input  logic [2:0]      mode,
  input  logic            st_clr_we,
  input  logic [NCNT-1:0] st_clr_mask,
  input  logic            act_clr,
  output logic [NCNT-1:0] status_q,
  output logic            act_q,
  output logic            irq_pmi,
  output logic            irq_fiq,
  output logic            halt_req
);
  logic cond;
  assign cond = (|(status_q & int_en)) && (mode != MODE_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      act_q    <= 1'b0;
      irq_pmi  <= 1'b0;
      irq_fiq  <= 1'b0;
      halt_req <= 1'b0;
    end else begin
      status_q <= (status_q & ~(st_clr_we ? st_clr_mask : '0)) | ovf;
      act_q    <= (act_q & ~act_clr) | cond;
      irq_pmi  <= cond && (mode == MODE_PMI);
      irq_fiq  <= cond && (mode == MODE_FIQ);
      halt_req <= cond && (mode == MODE_HALT);
    end
  end

  assert_one_line_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_pmi, irq_fiq, halt_req}));
  assert_mode_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |=> !(irq_pmi || irq_fiq || halt_req));
  assert_act_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (act_q && !act_clr) |=> act_q);
  assert_status_set_R6: assert property (@(posedge clk) disable iff (rst)
    (|ovf) |=> ((status_q & $past(ovf)) == $past(ovf)));
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
  import pmu_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int NEVT  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [4:0]        reg_wr_addr,
  input  logic [63:0]       reg_wr_data,
  input  logic              reg_rd_en,
  input  logic [4:0]        reg_rd_addr,
  output logic [63:0]       reg_rd_data,
  output logic              reg_rd_valid,
  input  logic              cyc_stb,
  input  logic              inst_stb,
  input  logic [NEVT-1:0]   evt_stb,
  input  logic              priv_kernel,
  output logic              irq_pmi,
  output logic              irq_fiq,
  output logic              halt_req
);
  localparam int EVT_W = $clog2(NEVT);

  logic [NCNT-1:0] cnt_en, int_en, usr_en, krn_en, ovf, hit, status_q;
  logic [NCNT-1:0][EVT_W-1:0] evsel;
  logic [NCNT-1:0][CNT_W-1:0] cnt_q;
  logic [2:0] mode;
  logic stop_on_int, act_q, freeze;
  logic [REG_W-1:0] ctrla_q, ctrlb_q, sela_q, selb_q;

  pmu_ctrl_regs #(.EVT_W(EVT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .cnt_en(cnt_en), .int_en(int_en),
    .usr_en(usr_en), .krn_en(krn_en), .evsel(evsel), .mode(mode),
    .stop_on_int(stop_on_int), .ctrla_q(ctrla_q), .ctrlb_q(ctrlb_q),
    .sela_q(sela_q), .selb_q(selb_q)
  );

  assign freeze = stop_on_int & act_q;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    if (i == 0) begin : g_cyc
      assign hit[i] = cyc_stb;
    end else if (i == 1) begin : g_ins
      assign hit[i] = inst_stb;
    end else begin : g_evt
      assign hit[i] = evt_stb[evsel[i]];
    end
    pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst),
      .wr_hit(reg_wr_en && (reg_wr_addr == ADDR_W'(i))),
      .wr_val(reg_wr_data[CNT_W-1:0]),
      .en(cnt_en[i]), .usr_en(usr_en[i]), .krn_en(krn_en[i]),
      .priv_kernel(priv_kernel), .freeze(freeze), .evt_hit(hit[i]),
      .cnt_q(cnt_q[i]), .ovf(ovf[i])
    );
  end

  pmu_irq u_irq (
    .clk(clk), .rst(rst), .ovf(ovf), .int_en(int_en), .mode(mode),
    .st_clr_we(reg_wr_en && (reg_wr_addr == A_STATUS)),
    .st_clr_mask(reg_wr_data[NCNT-1:0]),
    .act_clr(reg_wr_en && (reg_wr_addr == A_CTRLA) && !reg_wr_data[ACT_BIT]),
    .status_q(status_q), .act_q(act_q),
    .irq_pmi(irq_pmi), .irq_fiq(irq_fiq), .halt_req(halt_req)
  );

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_rd_addr < ADDR_W'(NCNT)) begin
      rd_mux = REG_W'(cnt_q[reg_rd_addr[3:0]]);
    end else begin
      case (reg_rd_addr)
        A_CTRLA:  rd_mux = ctrla_q | (REG_W'(act_q) << ACT_BIT);
        A_CTRLB:  rd_mux = ctrlb_q;
        A_SELA:   rd_mux = sela_q;
        A_SELB:   rd_mux = selb_q;
        A_STATUS: rd_mux = REG_W'(status_q);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_data  <= '0;
      reg_rd_valid <= 1'b0;
    end else begin
      reg_rd_valid <= reg_rd_en;
      reg_rd_data  <= reg_rd_en ? rd_mux : '0;
    end
  end

  assert_rd_valid_R11: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> reg_rd_valid);
endmodule

// File: tb/perf_monitor_tb.sv
module perf_monitor_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [4:0] reg_wr_addr = 0, reg_rd_addr = 0;
  logic [63:0] reg_wr_data = 0, reg_rd_data;
  logic reg_rd_valid;
  logic cyc_stb = 0, inst_stb = 0, priv_kernel = 0;
  logic [255:0] evt_stb = '0;
  logic irq_pmi, irq_fiq, halt_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_monitor u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid),
    .cyc_stb(cyc_stb), .inst_stb(inst_stb), .evt_stb(evt_stb),
    .priv_kernel(priv_kernel), .irq_pmi(irq_pmi), .irq_fiq(irq_fiq),
    .halt_req(halt_req)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];
  logic [63:0] ca = 0, cb = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && reg_rd_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected read data", 1, 0);
      else check(tag_q.pop_front(), reg_rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [63:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd_en = 1; reg_rd_addr = a;
    @(negedge clk);
    reg_rd_en = 0;
    @(negedge clk);
  endtask

  task automatic pulse(input int idx, input int n);
    @(negedge clk);
    evt_stb[idx] = 1;
    repeat (n) @(negedge clk);
    evt_stb[idx] = 0;
  endtask

  task automatic lines(input string tag, input logic [2:0] e);
    check(tag, {irq_pmi, irq_fiq, halt_req}, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    rd(5'h10, 0, "R10 ctrlA reset");
    rd(5'h14, 0, "R10 status reset");
    rd(5'h05, 0, "R10 counter5 reset");
    lines("R10 irq lines reset", 3'b000);

    // R2 R4 R5: fixed counters, user level
    ca = 64'h3; cb = 64'h300;
    wr(5'h10, ca); wr(5'h11, cb);
    @(negedge clk); cyc_stb = 1; repeat (5) @(negedge clk); cyc_stb = 0;
    inst_stb = 1; repeat (3) @(negedge clk); inst_stb = 0;
    rd(5'h00, 5, "R2 cycle counter");
    rd(5'h01, 3, "R2 instruction counter");

    // R5 R3: counter 2 event 0x40, kernel only
    wr(5'h12, 64'h0000_5540);
    ca |= 64'h4; cb |= (64'h1 << 18) | (64'h1 << 19);
    wr(5'h10, ca); wr(5'h11, cb);
    pulse(8'h40, 4);
    rd(5'h02, 0, "R5 user level filtered");
    priv_kernel = 1;
    pulse(8'h40, 3);
    rd(5'h02, 3, "R5 kernel level counted");
    pulse(8'h41, 2);
    rd(5'h02, 3, "R3 unselected strobe ignored");
    pulse(8'h55, 4);
    rd(5'h03, 0, "R4 disabled counter holds");

    // R3 R4 R5 high fields: counter 9 event 0x07
    wr(5'h13, 64'h0707_0000);
    ca |= 64'h1 << 33; cb |= 64'h1 << 49;
    wr(5'h10, ca); wr(5'h11, cb);
    pulse(8'h07, 2);
    rd(5'h09, 2, "R4 counter9 high enable");
    rd(5'h08, 0, "R4 counter8 not enabled");

    // R1 write wins over increment
    @(negedge clk);
    evt_stb[8'h40] = 1; reg_wr_en = 1; reg_wr_addr = 5'h02; reg_wr_data = 64'h123;
    @(negedge clk);
    evt_stb[8'h40] = 0; reg_wr_en = 0;
    rd(5'h02, 64'h123, "R1 write priority");

    // R6 R7 overflow with PMI and stop-on-interrupt
    wr(5'h02, 64'h7FFF_FFFF_FFFE);
    ca |= (64'h1 << 8) | (64'h1 << 14) | (64'h1 << 20);
    wr(5'h10, ca);
    pulse(8'h40, 1);
    rd(5'h02, 64'h7FFF_FFFF_FFFF, "R6 just below overflow");
    rd(5'h14, 0, "R6 no status yet");
    lines("R7 no interrupt yet", 3'b000);
    pulse(8'h40, 1);
    @(negedge clk);
    lines("R7 PMI line", 3'b100);
    rd(5'h02, 64'h8000_0000_0000, "R6 counter crossed bit47");
    rd(5'h14, 64'h4, "R6 status bit2");
    rd(5'h10, ca | (64'h1 << 11), "R8 active flag set");

    // R9 frozen while active
    pulse(8'h40, 3);
    pulse(8'h07, 2);
    rd(5'h02, 64'h8000_0000_0000, "R9 counter2 frozen");
    rd(5'h09, 2, "R9 counter9 frozen");

    // R8 cannot clear while pending; R6 W1C
    wr(5'h10, ca);
    rd(5'h10, ca | (64'h1 << 11), "R8 active held while pending");
    wr(5'h14, 64'h4);
    rd(5'h14, 0, "R6 write one clears");
    wr(5'h10, ca);
    rd(5'h10, ca, "R8 active cleared");
    lines("R7 PMI dropped", 3'b000);
    pulse(8'h40, 1);
    rd(5'h02, 64'h8000_0000_0001, "R9 counting resumes");

    // R7 mode off: status only
    wr(5'h12, 64'h0060_5540);
    ca = (ca & ~(64'h7 << 8)) | (64'h1 << 4) | (64'h1 << 16);
    cb |= 64'h1 << 20;
    wr(5'h10, ca); wr(5'h11, cb);
    wr(5'h04, 64'h7FFF_FFFF_FFFF);
    pulse(8'h60, 1);
    repeat (2) @(negedge clk);
    lines("R7 mode off no line", 3'b000);
    rd(5'h14, 64'h10, "R6 status bit4");
    rd(5'h10, ca, "R8 no active in mode off");

    // R7 FIQ then halt
    wr(5'h10, ca | (64'h4 << 8));
    repeat (2) @(negedge clk);
    lines("R7 FIQ line", 3'b010);
    wr(5'h10, ca | (64'h3 << 8));
    repeat (2) @(negedge clk);
    lines("R7 halt line", 3'b001);
    wr(5'h14, 64'h10);
    wr(5'h10, ca);
    repeat (2) @(negedge clk);
    lines("R7 all clear", 3'b000);
    rd(5'h10, ca, "R8 cleared after halt");

    // R11 unmapped
    rd(5'h1F, 0, "R11 unmapped read");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R11 pending reads", exp_q.size(), 0);
    finish_run();
  end
endmodule